// File: doc/BRIEF.md
# Runt-Free Gated Clock Fanout

This block distributes one of two incoming clocks to four identical output pairs, each pair carrying a true copy and its complement. A select input picks the source clock. An enable input, which may change at any moment with no timing relation to either clock, switches all outputs on or off together. When the outputs are off, every true copy is held low and every complement copy is held high.

The enable first passes through a synchronizer that runs on the selected clock. One register captures it on a rising edge, and a second register moves it across on the following falling edge. The gate therefore changes only while the clock is low. Each output pulse is either emitted in full or not emitted at all, so an enable change never produces a shortened high phase.

An active-low asynchronous reset clears both synchronizer registers, which forces the outputs into the off state. The source select may be changed only while the outputs are off.

Top module: `clk_fanout_gated`

## Requirements
- R1: With `src_sel` = 0 the outputs carry `clk_a`; with `src_sel` = 1 they carry `clk_b`. Each output high pulse lasts exactly as long as the high phase of the selected clock.
- R2: After `en_async` rises during a low phase of the selected clock, the next rising edge still gives no output pulse. The first output pulse starts at the second rising edge.
- R3: After `en_async` falls during a low phase, the pulse that starts at the next rising edge is still emitted in full. No pulse is emitted from the second rising edge onward.
- R4: While the block is off, every bit of `q` is 0 and every bit of `qn` is 1.
- R5: While the block is on, `q` follows the selected clock and `qn` is the bitwise inverse of `q` at every sample.
- R6: All `NUM_OUTS` (default 4) true outputs carry the same value at all times.
- R7: No runt pulses: the outputs are low whenever the selected clock is low, and every output high pulse spans a whole high phase of that clock.
- R8: Driving `rst_n` low clears the synchronizer at once and turns the outputs off. After `rst_n` is released with `en_async` high, the first pulse starts at the second rising edge of the selected clock.
- R9: An enable change made during a high phase follows the same edge count as R2 and R3. The pulse in progress is not cut short, the next pulse keeps the old state, and the pulse after it takes the new state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | First source clock, chosen when `src_sel` is 0 |
| clk_b | input | 1 | Second source clock, chosen when `src_sel` is 1 |
| src_sel | input | 1 | Source select |
| en_async | input | 1 | Output enable, asynchronous to both clocks |
| rst_n | input | 1 | Active-low asynchronous reset of the synchronizer |
| q | output | NUM_OUTS | True outputs of the gated clock |
| qn | output | NUM_OUTS | Complement outputs of the gated clock |

## Verification
The bound checker checks four things on every edge of the selected clock:
- the complement relation between `q` and `qn`;
- the agreement among the copies;
- the low level of the outputs during each low phase;
- that each emitted pulse matches the enable value sampled the required number of rising edges earlier.

Some behaviour can only be shown by the bench's scenarios: the full width of pulses measured in time on each source clock, the source routing after a select change, and the off state during and after a reset.

// File: rtl/cfo_pkg.sv
package cfo_pkg;

   // Source choice encoded by the select input
   typedef enum logic {
      SRC_A = 1'b0,
      SRC_B = 1'b1
   } cfo_src_e;

   // Level held by a true output while the block is off
   localparam logic OFF_LEVEL_TRUE = 1'b0;

   function automatic logic cfo_gate(input logic clk, input logic en);
      return clk & en;
   endfunction

endpackage

// File: rtl/cfo_src_mux.sv
module cfo_src_mux
   import cfo_pkg::*;
(
   input  logic clk_a,
   input  logic clk_b,
   input  logic sel,
   output logic clk_out
);

   cfo_src_e src;

   assign src     = cfo_src_e'(sel);
   assign clk_out = (src == SRC_B) ? clk_b : clk_a;

endmodule

// File: rtl/cfo_en_sync.sv
module cfo_en_sync #(
   parameter int RISE_STAGES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_async,
   output logic en_gate
);

   logic [RISE_STAGES-1:0] rise_q;
   logic                   fall_q;

   // Capture on rising edges (optionally several for extra settling)
   generate
      if (RISE_STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rise_q <= '0;
            else        rise_q <= en_async;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rise_q <= '0;
            else        rise_q <= {rise_q[RISE_STAGES-2:0], en_async};
         end
      end
   endgenerate

   // Hand over on the falling edge so the gate moves only in the low phase
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) fall_q <= 1'b0;
      else        fall_q <= rise_q[RISE_STAGES-1];
   end

   assign en_gate = fall_q;

endmodule

// File: rtl/cfo_fanout.sv
module cfo_fanout
   import cfo_pkg::*;
#(
   parameter int NUM_OUTS = 4
) (
   input  logic                clk,
   input  logic                en_gate,
   output logic [NUM_OUTS-1:0] q,
   output logic [NUM_OUTS-1:0] qn
);

   logic gated;

   assign gated = cfo_gate(clk, en_gate);

   generate
      for (genvar i = 0; i < NUM_OUTS; i++) begin : g_pair
         assign q[i]  = gated;
         assign qn[i] = ~gated;
      end
   endgenerate

endmodule

// File: rtl/clk_fanout_gated.sv
module clk_fanout_gated #(
   parameter int NUM_OUTS    = 4,
   parameter int RISE_STAGES = 1
) (
   input  logic                clk_a,
   input  logic                clk_b,
   input  logic                src_sel,
   input  logic                en_async,
   input  logic                rst_n,
   output logic [NUM_OUTS-1:0] q,
   output logic [NUM_OUTS-1:0] qn
);

   generate
      if (NUM_OUTS < 1) begin : g_bad_outs
         $error("clk_fanout_gated: NUM_OUTS must be at least 1");
      end
      if (RISE_STAGES < 1) begin : g_bad_stages
         $error("clk_fanout_gated: RISE_STAGES must be at least 1");
      end
   endgenerate

   logic sel_clk;
   logic en_gate;

   cfo_src_mux u_mux (
      .clk_a   (clk_a),
      .clk_b   (clk_b),
      .sel     (src_sel),
      .clk_out (sel_clk)
   );

   cfo_en_sync #(
      .RISE_STAGES (RISE_STAGES)
   ) u_sync (
      .clk      (sel_clk),
      .rst_n    (rst_n),
      .en_async (en_async),
      .en_gate  (en_gate)
   );

   cfo_fanout #(
      .NUM_OUTS (NUM_OUTS)
   ) u_fan (
      .clk     (sel_clk),
      .en_gate (en_gate),
      .q       (q),
      .qn      (qn)
   );

endmodule

// File: rtl/clk_fanout_gated_chk.sv
module clk_fanout_gated_chk #(
   parameter int NUM_OUTS    = 4,
   parameter int RISE_STAGES = 1
) (
   input logic                clk_a,
   input logic                clk_b,
   input logic                src_sel,
   input logic                en_async,
   input logic                rst_n,
   input logic [NUM_OUTS-1:0] q,
   input logic [NUM_OUTS-1:0] qn
);

   localparam int DEPTH = RISE_STAGES + 1;
   localparam int VW    = $clog2(DEPTH + 1);

   logic             sclk;
   logic [DEPTH-1:0] hist;
   logic [VW-1:0]    seen;

   assign sclk = src_sel ? clk_b : clk_a;

   // Enable values seen at recent rising edges, and edges counted since reset
   always_ff @(posedge sclk or negedge rst_n) begin
      if (!rst_n) begin
         hist <= '0;
         seen <= '0;
      end else begin
         hist <= {hist[DEPTH-2:0], en_async};
         if (seen != VW'(DEPTH)) seen <= seen + 1'b1;
      end
   end

   AST_PAIR_INVERSE: assert property (@(negedge sclk) disable iff (!rst_n)
      qn == ~q); // R5

   AST_COPIES_MATCH: assert property (@(negedge sclk) disable iff (!rst_n)
      ($countones(q) == 0) || ($countones(q) == NUM_OUTS)); // R6

   AST_LOW_WHILE_CLK_LOW: assert property (@(posedge sclk) disable iff (!rst_n)
      q == '0); // R7

   AST_GATE_AFTER_EDGES: assert property (@(negedge sclk) disable iff (!rst_n)
      (seen == VW'(DEPTH)) |-> (q[0] == hist[DEPTH-1])); // R2 R3

   AST_RESET_OFF: assert property (@(negedge sclk)
      !rst_n |-> (q == '0 && qn == '1)); // R8

endmodule

bind clk_fanout_gated clk_fanout_gated_chk #(
   .NUM_OUTS    (NUM_OUTS),
   .RISE_STAGES (RISE_STAGES)
) u_chk (
   .clk_a    (clk_a),
   .clk_b    (clk_b),
   .src_sel  (src_sel),
   .en_async (en_async),
   .rst_n    (rst_n),
   .q        (q),
   .qn       (qn)
);

// File: tb/clk_fanout_gated_tb.sv
`timescale 1ns/1ps
module clk_fanout_gated_tb;

   localparam int N = 4;

   logic         clk_a = 1'b0;
   logic         clk_b = 1'b0;
   logic         src_sel = 1'b0;
   logic         en_async = 1'b1;
   logic         rst_n = 1'b0;
   logic [N-1:0] q;
   logic [N-1:0] qn;
   logic         selclk;

   always #4 clk_a = ~clk_a;   // 125 MHz
   always #6 clk_b = ~clk_b;

   assign selclk = src_sel ? clk_b : clk_a;

   clk_fanout_gated #(.NUM_OUTS(N)) u_dut (
      .clk_a    (clk_a),
      .clk_b    (clk_b),
      .src_sel  (src_sel),
      .en_async (en_async),
      .rst_n    (rst_n),
      .q        (q),
      .qn       (qn)
   );

   typedef struct {
      bit    lvl;
      string tag;
   } exp_t;

   exp_t sbq[$];
   int   n_cmp = 0;
   int   n_bad = 0;
   real  exp_half = 4.0;
   bit   cur = 1'b0;

   task automatic report(input bit ok, input string tag, input string msg);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: %s", tag, msg);
      end
   endtask

   // Monitor: after every rising edge of the selected clock, compare with the next expected item
   initial begin
      forever begin
         exp_t e;
         @(posedge selclk);
         if (sbq.size() > 0) begin
            e = sbq.pop_front();
            #1;
            report(q == {N{e.lvl}}, e.tag,
                   $sformatf("q actual %b expected %b", q, {N{e.lvl}}));
            report(qn == ~q, e.lvl ? "R5" : "R4",
                   $sformatf("qn actual %b expected %b", qn, ~q));
            report(($countones(q) == 0) || ($countones(q) == N), "R6",
                   $sformatf("copies actual %b expected all equal", q));
         end
      end
   end

   // Pulse width monitor (R7, R1)
   initial begin
      forever begin
         realtime t0, w;
         @(posedge q[0]);
         t0 = $realtime;
         @(negedge q[0]);
         w = $realtime - t0;
         report((w > exp_half - 0.01) && (w < exp_half + 0.01), "R7",
                $sformatf("pulse width actual %0.3f expected %0.3f", w, exp_half));
      end
   end

   // Driver: push expectations for n rising edges, then apply the stimulus
   task automatic window(input bit new_en, input bit new_rst, input bit in_high,
                         input int n, input string tag_first, input string tag_rest);
      bit first, rest;
      if (in_high) @(posedge selclk);
      else         @(negedge selclk);
      #1;
      first = new_rst ? cur : 1'b0;
      rest  = new_rst ? new_en : 1'b0;
      sbq.push_back('{first, tag_first});
      for (int i = 1; i < n; i++) sbq.push_back('{rest, tag_rest});
      rst_n    = new_rst;
      en_async = new_en;
      cur      = rest;
      repeat (n) @(posedge selclk);
      #2;
   endtask

   task automatic switch_src(input bit s, input real half);
      @(negedge selclk);
      #1;
      src_sel  = s;
      exp_half = half;
      repeat (3) @(posedge selclk);
      #2;
   endtask

   initial begin
      // Reset state: outputs off while reset is held with the enable high
      #3;
      report(q == '0, "R8", $sformatf("q in reset actual %b expected 0", q));
      report(qn == '1, "R4", $sformatf("qn in reset actual %b expected all ones", qn));
      repeat (2) @(posedge clk_a);
      #1;
      report(q == '0, "R8", $sformatf("q in reset actual %b expected 0", q));

      window(1'b1, 1'b1, 1'b0, 5, "R8", "R8");   // release reset
      window(1'b0, 1'b1, 1'b0, 4, "R3", "R3");   // disable in low phase
      window(1'b1, 1'b1, 1'b0, 4, "R2", "R2");   // enable in low phase
      window(1'b0, 1'b1, 1'b1, 4, "R9", "R9");   // disable in high phase
      window(1'b1, 1'b1, 1'b1, 4, "R9", "R9");   // enable in high phase
      window(1'b0, 1'b1, 1'b0, 3, "R3", "R4");

      switch_src(1'b1, 6.0);
      window(1'b1, 1'b1, 1'b0, 6, "R2", "R1");
      window(1'b0, 1'b1, 1'b0, 3, "R3", "R4");
      window(1'b1, 1'b1, 1'b1, 4, "R9", "R1");
      window(1'b1, 1'b0, 1'b0, 4, "R8", "R8");   // reset while enabled
      window(1'b1, 1'b1, 1'b0, 4, "R8", "R8");
      window(1'b0, 1'b1, 1'b0, 3, "R3", "R4");

      switch_src(1'b0, 4.0);
      window(1'b1, 1'b1, 1'b0, 5, "R2", "R1");
      window(1'b0, 1'b1, 1'b1, 3, "R9", "R4");

      #20;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #1600000;
      report(1'b0, "watchdog", "run did not complete, actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule